// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block is the device side of a receive path that lands incoming frames in host memory through a ring of descriptors. Each ring entry is 16 bytes long. The word at offset 0 holds the host buffer address. The word at offset 4 holds a 16-bit buffer length in the low half and a 16-bit status in the high half. The word at offset 8 holds the message length, and the word at offset 12 is unused. The host stores the buffer length negated. It hands an entry to the device by setting status bit 15.

When a frame starts, the engine reads the current entry. If the device does not own that entry, the engine consumes the frame, writes nothing, bumps a missed-frame counter and keeps its ring position.

If the device owns the entry, the engine then:
- fetches the buffer address;
- packs the frame bytes little-endian into 32-bit writes, clipping anything beyond the buffer;
- writes the stored byte count;
- writes the status last, with ownership cleared, the start and end markers set and any error causes flagged;
- steps to the next ring slot, wrapping at 2^N entries.

The frame stream already carries the four FCS bytes, so the reported length includes them.

Top module: `rx_desc_wb`

## Requirements
- R1: On the first valid byte of a frame, the engine reads the word at entry offset 4. For an owned entry it then reads offset 0 and uses that word as the buffer base address. The entry address is ring_base + 16 × index.
- R2: Bit 31 of the offset-4 word (status bit 15) set means the device owns the entry. If it is clear, the whole frame is accepted and discarded, no memory write happens, missed_count rises by one (saturating), and the ring index does not move.
- R3: The buffer size in bytes is the two's complement negation of the low 16 bits of the offset-4 word.
- R4: Frame byte k is stored at buffer base + k, using 32-bit writes whose byte strobes cover only the bytes of that frame. The buffer base is assumed word-aligned.
- R5: The word at entry offset 8 is written with the number of stored bytes, FCS included, in bits 11:0 and zero above.
- R6: The status is written with strobe 4'b1100 at offset 4, so the buffer length field is left unchanged. In the status, bit 15 is 0, bits 9:8 are 1 (start and end of frame), and the low byte is 0.
- R7: The error flags sampled with the last byte set status bit 13 (framing), bit 12 (overflow) and bit 11 (CRC).
- R8: Bytes beyond the buffer size are dropped, not written. Status bit 10 is set and the reported length equals the buffer size.
- R9: The status write is the last memory write for a frame. It follows every data write and the length write.
- R10: The ring holds 2^N entries, where N is ring_order, the 4-bit field the setup logic takes from bits 7:4 of the ring-length halfword. The index advances only after a written frame, and wraps to 0.
- R11: After reset, in_ready and mem_req are low, missed_count is 0 and the ring index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | AW | Byte address of ring entry 0 |
| ring_order | input | 4 | Log2 of the ring entry count |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_err_frame | input | 1 | Framing error, valid with in_last |
| in_err_ovf | input | 1 | Overflow error, valid with in_last |
| in_err_crc | input | 1 | CRC error, valid with in_last |
| in_ready | output | 1 | Engine takes the byte this cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte strobes for writes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| missed_count | output | MISS_W | Frames dropped for lack of an owned entry |

## Verification
Some properties are checked on every cycle:
- Any status write clears ownership, carries both frame markers and touches only the upper halfword.
- A status write is always preceded by the length write, with no data word still pending.
- Data writes stay inside the fetched buffer, and their strobes are contiguous from lane 0.
- No read is issued while bytes are being taken.
- The missed counter only ever steps by one.

Other behaviour can only be shown by the bench's frame scenarios:
- the stored bytes and partial-word strobes;
- the exact error bits and length values;
- clipping at a small buffer;
- a dropped frame leaving memory untouched;
- ring wrap at four entries and at a single entry.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_CTL,
    ST_CHK_CTL,
    ST_RD_BUF,
    ST_GET_BUF,
    ST_DATA,
    ST_DROP,
    ST_LEN,
    ST_STAT
  } rxwb_state_e;

  localparam int ENTRY_SHIFT = 4;
  localparam int LEN_W       = 12;

  // Host stores the buffer length negated; recover the byte count.
  function automatic logic [15:0] buf_size_from_field(input logic [15:0] field);
    return ~field + 16'd1;
  endfunction

  // Status halfword written back for a completed frame.
  function automatic logic [15:0] wb_status(input logic fe, input logic ov,
                                            input logic crc, input logic bf);
    logic [15:0] s;
    s     = 16'h0300;
    s[13] = fe;
    s[12] = ov;
    s[11] = crc;
    s[10] = bf;
    return s;
  endfunction

  // Strobes covering lanes 0..lane.
  function automatic logic [3:0] lane_strobe(input logic [1:0] lane);
    case (lane)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      2'd2:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/rxwb_ring_ptr.sv
module rxwb_ring_ptr #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       order,
  input  logic             advance,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < IDX_W; b++) mask[b] = (b < int'(order));
  end

  assign idx = idx_q & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= (idx + IDX_W'(1)) & mask;
  end
endmodule

// File: rtl/rxwb_miss_counter.sv
module rxwb_miss_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (inc && count != '1)   count <= count + W'(1);
  end
endmodule

// File: rtl/rxwb_byte_packer.sv
module rxwb_byte_packer
  import rxwb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [1:0]    lane,
  input  logic [7:0]    byte_in,
  input  logic          flush,
  input  logic [AW-1:0] waddr,
  input  logic          pop,
  output logic          pend,
  output logic [AW-1:0] addr,
  output logic [31:0]   data,
  output logic [3:0]    strb
);
  logic [23:0] acc;
  logic [31:0] merged;

  always_comb begin
    merged = {8'h00, acc};
    case (lane)
      2'd0:    merged[7:0]   = byte_in;
      2'd1:    merged[15:8]  = byte_in;
      2'd2:    merged[23:16] = byte_in;
      default: merged[31:24] = byte_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      pend <= 1'b0;
      addr <= '0;
      data <= '0;
      strb <= '0;
    end else begin
      if (push && flush) begin
        pend <= 1'b1;
        addr <= waddr;
        data <= merged;
        strb <= lane_strobe(lane);
        acc  <= '0;
      end else begin
        if (pop)  pend <= 1'b0;
        if (push) acc  <= merged[23:0];
      end
    end
  end
endmodule

// File: rtl/rx_desc_wb.sv
module rx_desc_wb
  import rxwb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int IDX_W  = 9,
  parameter int POS_W  = 16,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ring_base,
  input  logic [3:0]        ring_order,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_err_frame,
  input  logic              in_err_ovf,
  input  logic              in_err_crc,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic [31:0]       mem_rdata,
  output logic [MISS_W-1:0] missed_count
);
  rxwb_state_e      state_q, state_d;
  logic [AW-1:0]    buf_base_q;
  logic [15:0]      buf_size_q;
  logic [POS_W-1:0] pos_q;
  logic [LEN_W-1:0] stored_q;
  logic             trunc_q, fe_q, ov_q, crc_q;

  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    entry_addr;
  logic             accept, in_buf, at_buf_end, push, flush;
  logic [AW-1:0]    waddr;
  logic             pend;
  logic [AW-1:0]    pend_addr;
  logic [31:0]      pend_data;
  logic [3:0]       pend_strb;

  // Named events, brought out for the checker.
  logic ev_data_wr, ev_len_wr, ev_stat_wr, ev_miss, ev_advance;

  assign entry_addr = ring_base + (AW'(idx) << ENTRY_SHIFT);
  assign in_ready   = (state_q == ST_DATA) || (state_q == ST_DROP);
  assign accept     = in_valid && in_ready;
  assign in_buf     = pos_q < POS_W'(buf_size_q);
  assign at_buf_end = POS_W'(pos_q + POS_W'(1)) == POS_W'(buf_size_q);
  assign push       = accept && (state_q == ST_DATA) && in_buf;
  assign flush      = (pos_q[1:0] == 2'b11) || in_last || at_buf_end;
  assign waddr      = buf_base_q + AW'({pos_q[POS_W-1:2], 2'b00});

  assign ev_data_wr = pend && ((state_q == ST_DATA) || (state_q == ST_LEN));
  assign ev_len_wr  = (state_q == ST_LEN) && !pend;
  assign ev_stat_wr = (state_q == ST_STAT);
  assign ev_advance = ev_stat_wr;
  assign ev_miss    = accept && in_last && (state_q == ST_DROP);

  rxwb_ring_ptr #(.IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .order(ring_order),
    .advance(ev_advance), .idx(idx)
  );

  rxwb_miss_counter #(.W(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .inc(ev_miss), .count(missed_count)
  );

  rxwb_byte_packer #(.AW(AW)) u_pack (
    .clk(clk), .rst_n(rst_n), .push(push), .lane(pos_q[1:0]),
    .byte_in(in_data), .flush(flush), .waddr(waddr), .pop(ev_data_wr),
    .pend(pend), .addr(pend_addr), .data(pend_data), .strb(pend_strb)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (in_valid) state_d = ST_RD_CTL;
      ST_RD_CTL:  state_d = ST_CHK_CTL;
      ST_CHK_CTL: state_d = mem_rdata[31] ? ST_RD_BUF : ST_DROP;
      ST_RD_BUF:  state_d = ST_GET_BUF;
      ST_GET_BUF: state_d = ST_DATA;
      ST_DATA:    if (accept && in_last) state_d = ST_LEN;
      ST_DROP:    if (accept && in_last) state_d = ST_IDLE;
      ST_LEN:     if (!pend) state_d = ST_STAT;
      ST_STAT:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wstrb = '0;
    case (state_q)
      ST_RD_CTL: begin
        mem_req  = 1'b1;
        mem_addr = entry_addr + AW'(4);
      end
      ST_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = entry_addr;
      end
      ST_DATA, ST_LEN: begin
        if (pend) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = pend_addr;
          mem_wdata = pend_data;
          mem_wstrb = pend_strb;
        end else if (state_q == ST_LEN) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = entry_addr + AW'(8);
          mem_wdata = {{(32-LEN_W){1'b0}}, stored_q};
          mem_wstrb = 4'b1111;
        end
      end
      ST_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = entry_addr + AW'(4);
        mem_wdata = {wb_status(fe_q, ov_q, crc_q, trunc_q), 16'h0000};
        mem_wstrb = 4'b1100;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      buf_base_q <= '0;
      buf_size_q <= '0;
      pos_q      <= '0;
      stored_q   <= '0;
      trunc_q    <= 1'b0;
      fe_q       <= 1'b0;
      ov_q       <= 1'b0;
      crc_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_IDLE: if (in_valid) begin
          pos_q    <= '0;
          stored_q <= '0;
          trunc_q  <= 1'b0;
          fe_q     <= 1'b0;
          ov_q     <= 1'b0;
          crc_q    <= 1'b0;
        end
        ST_CHK_CTL: buf_size_q <= buf_size_from_field(mem_rdata[15:0]);
        ST_GET_BUF: buf_base_q <= AW'(mem_rdata);
        ST_DATA: if (accept) begin
          pos_q <= pos_q + POS_W'(1);
          if (in_buf) stored_q <= stored_q + LEN_W'(1);
          else        trunc_q  <= 1'b1;
          if (in_last) begin
            fe_q  <= in_err_frame;
            ov_q  <= in_err_ovf;
            crc_q <= in_err_crc;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_wb_chk.sv
module rx_desc_wb_chk #(
  parameter int AW     = 32,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_wstrb,
  input logic [MISS_W-1:0] missed_count,
  input logic              ev_stat_wr,
  input logic              ev_len_wr,
  input logic              ev_data_wr,
  input logic              data_pend,
  input logic [AW-1:0]     buf_base,
  input logic [15:0]       buf_size
);
  p_own_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_wr |-> (mem_req && mem_we && !mem_wdata[31] &&
                    mem_wdata[25:24] == 2'b11 && mem_wstrb == 4'b1100));

  p_stat_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_wr |-> (!data_pend && $past(ev_len_wr)));

  p_miss_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_count != $past(missed_count)) |->
      (missed_count == $past(missed_count) + MISS_W'(1)));

  p_data_in_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_wr |-> ((mem_addr - buf_base) < AW'(buf_size)));

  p_strobe_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |->
      (mem_wstrb == 4'b0001 || mem_wstrb == 4'b0011 || mem_wstrb == 4'b0111 ||
       mem_wstrb == 4'b1111 || mem_wstrb == 4'b1100));

  p_no_read_in_stream_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !(mem_req && !mem_we));
endmodule

bind rx_desc_wb rx_desc_wb_chk #(.AW(AW), .MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_wstrb(mem_wstrb), .missed_count(missed_count),
  .ev_stat_wr(ev_stat_wr), .ev_len_wr(ev_len_wr), .ev_data_wr(ev_data_wr),
  .data_pend(pend), .buf_base(buf_base_q), .buf_size(buf_size_q)
);

// File: tb/rx_desc_wb_tb.sv
`timescale 1ns/1ps
module rx_desc_wb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic [3:0]  ring_order = 4'd2;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_err_frame = 1'b0, in_err_ovf = 1'b0, in_err_crc = 1'b0;
  logic        in_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;
  logic [15:0] missed_count;

  logic        hw_en = 1'b0, fill_en = 1'b0;
  logic [31:0] hw_addr = '0, hw_data = '0;
  logic [31:0] mem [0:1023];
  logic [31:0] last_wa;
  logic [3:0]  last_ws;

  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  rx_desc_wb u_dut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_order(ring_order),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err_frame(in_err_frame), .in_err_ovf(in_err_ovf), .in_err_crc(in_err_crc),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
    .missed_count(missed_count)
  );

  // Memory model: 4 KB, one-cycle read latency, byte strobes.
  always @(posedge clk) begin
    if (fill_en) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 32'hA5A5A5A5;
    end else if (hw_en) begin
      mem[hw_addr[11:2]] <= hw_data;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_wstrb[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        last_wa <= mem_addr;
        last_ws <= mem_wstrb;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  // Frame table: {length[27:16], buffer size[15:4], own, framing, overflow, crc}
  localparam logic [27:0] VEC [6] = '{
    {12'd64, 12'd1544, 4'b1000},
    {12'd70, 12'd1544, 4'b1001},
    {12'd10, 12'd1544, 4'b0000},
    {12'd66, 12'd64,   4'b1100},
    {12'd61, 12'd1544, 4'b1010},
    {12'd63, 12'd1544, 4'b1000}
  };

  function automatic logic [7:0] byte_of(input int seed, input int k);
    return 8'(seed * 31 + k * 3 + 1);
  endfunction

  function automatic logic [7:0] rd_byte(input int a);
    logic [31:0] w;
    w = mem[a / 4];
    return w[8 * (a % 4) +: 8];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic send_frame(input int seed, input int len, input logic fe,
                            input logic ov, input logic crc);
    logic r;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid     = 1'b1;
      in_data      = byte_of(seed, k);
      in_last      = (k == len - 1);
      in_err_frame = (k == len - 1) ? fe : 1'b0;
      in_err_ovf   = (k == len - 1) ? ov : 1'b0;
      in_err_crc   = (k == len - 1) ? crc : 1'b0;
      forever begin
        #1;
        r = in_ready;
        @(posedge clk);
        if (r) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    in_err_frame = 1'b0; in_err_ovf = 1'b0; in_err_crc = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int slot;
    int mism;
    logic [11:0] vlen, vbuf;
    logic vown, vfe, vov, vcrc, vtr;
    logic [11:0] stored;
    logic [31:0] desc, bufa, w1_exp, prev_miss;
    logic [7:0]  hi;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 in_ready in reset", {31'b0, in_ready}, 32'd0);
    chk("R11 mem_req in reset", {31'b0, mem_req}, 32'd0);
    chk("R11 missed_count in reset", {16'b0, missed_count}, 32'd0);
    @(negedge clk); fill_en = 1'b1;
    @(negedge clk); fill_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {30'b0, in_ready, mem_req}, 32'd0);

    slot = 0;
    for (int i = 0; i < 6; i++) begin
      vlen = VEC[i][27:16]; vbuf = VEC[i][15:4];
      vown = VEC[i][3]; vfe = VEC[i][2]; vov = VEC[i][1]; vcrc = VEC[i][0];
      vtr    = (vlen > vbuf);
      stored = vtr ? vbuf : vlen;
      desc   = 32'h100 + 32'(slot * 16);
      bufa   = 32'h800 + 32'(i * 128);
      w1_exp = {vown ? 16'h8000 : 16'h0000, 16'h0000 - {4'b0, vbuf}};
      host_wr(desc, bufa);
      host_wr(desc + 4, w1_exp);
      host_wr(desc + 8, 32'hFFFFFFFF);
      prev_miss = {16'b0, missed_count};
      send_frame(i, int'(vlen), vfe, vov, vcrc);
      if (vown) begin
        hi = 8'h03 | {2'b0, vfe, vov, vcrc, vtr, 2'b0};
        chk("R6 R7 R8 R10 status word", mem[desc[11:2] + 1],
            {hi, 8'h00, 16'h0000 - {4'b0, vbuf}});
        chk("R5 R8 message length", mem[desc[11:2] + 2], {20'b0, stored});
        mism = 0;
        for (int k = 0; k < int'(stored); k++)
          if (rd_byte(int'(bufa) + k) !== byte_of(i, k)) mism++;
        chk("R1 R4 stored bytes", 32'(mism), 32'd0);
        chk("R3 R4 R8 byte after stored data", {24'b0, rd_byte(int'(bufa) + int'(stored))}, 32'hA5);
        chk("R9 last write is status", {last_wa[27:0], last_ws}, {desc[27:0] + 28'd4, 4'b1100});
        chk("R2 owned frame not missed", {16'b0, missed_count}, prev_miss);
        slot = (slot + 1) % 4;
      end else begin
        chk("R2 unowned entry untouched", mem[desc[11:2] + 1], w1_exp);
        chk("R2 unowned buffer untouched", mem[bufa[11:2]], 32'hA5A5A5A5);
        chk("R2 missed count step", {16'b0, missed_count}, prev_miss + 1);
      end
    end

    // R10: single-entry ring, both frames land in entry 0, entry 1 untouched
    ring_order = 4'd0;
    host_wr(32'h110, 32'hC00);
    host_wr(32'h114, 32'h8000FA00);
    for (int j = 0; j < 2; j++) begin
      host_wr(32'h100, 32'hC80 + 32'(j * 64));
      host_wr(32'h104, 32'h8000F9F8);
      send_frame(10 + j, 60 + j, 1'b0, 1'b0, 1'b0);
      chk("R10 single-entry ring status", mem[32'h104 >> 2], 32'h0300F9F8);
      chk("R10 single-entry ring length", mem[32'h108 >> 2], 32'(60 + j));
    end
    chk("R10 entry 1 unused with N=0", mem[32'h114 >> 2], 32'h8000FA00);

    // R11: reset clears missed counter
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R11 missed cleared by reset", {16'b0, missed_count}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule